// File: doc/BRIEF.md
# Parity-Guarded Instruction Scratchpad

This block is an on-chip instruction scratchpad of 4 KB, organised as 1024 words of 32 bits. Each stored word carries two interleaved parity bits. One bit covers the data bits at even positions and the other covers the bits at odd positions. The pair is computed and stored together with the data on every write. The block only detects errors. It has no in-place correction logic.

Every fetch returns the word one cycle after the request, together with a verdict. If the stored parity no longer matches the data, the response is marked as an error and not as valid. The block then raises a sticky recovery interrupt and records the word address of the fault. A recovery routine reads the fault address and the computed backup location, which is a programmable backup base plus the byte offset of the word. It copies the clean word from main memory back through the ordinary write port, which recomputes the parity, and then clears the interrupt with a write-one-to-clear.

A separate upset port flips chosen stored bits in place. It models soft errors so the detection path can be exercised.

Top module: `ispm_guard`

## Requirements
- R1: A write stores the 32-bit data with parity pair {p1,p0}, where p0 is the XOR of data bits 0,2,4,…,30 and p1 is the XOR of bits 1,3,…,31. The pair is stored as bits 33:32 of the stored word. A fetch request accepted at a clock edge presents the data on fetch_data, with fetch_valid high, in the cycle after that edge.
- R2: When the stored parity of the fetched word mismatches, fetch_err is high and fetch_valid is low in the response cycle. fetch_valid and fetch_err are never high together.
- R3: A mismatch in a response cycle sets irq at the next clock edge and records the word address in fault_addr. irq then stays high until it is cleared.
- R4: While irq is high, a fetch of the word at fault_addr is answered with fetch_err high and fetch_valid low, even if its parity is now correct.
- R5: A CSR write with csr_sel=1 and csr_wdata[0]=1 clears irq at the next edge. The same write with csr_wdata[0]=0 has no effect. A mismatch in the same cycle as a clear wins: irq stays high and fault_addr takes the new address.
- R6: Mismatches at other addresses while irq is high do not change fault_addr.
- R7: A CSR write with csr_sel=0 loads backup_base from csr_wdata. backup_addr always equals backup_base + 4×fault_addr, modulo 2^32.
- R8: Rewriting a corrupted word through the write port recomputes its parity. After the interrupt is cleared, a fetch of that word is valid and returns the restored data.
- R9: Any upset that flips an odd number of bits within either parity group is detected, including a single parity bit and any burst of 2 or 3 adjacent data bits. An upset flipping two bits of the same group goes undetected, and the altered word is returned as valid.
- R10: After reset, irq, fault_addr, backup_base, backup_addr, fetch_valid and fetch_err are all zero.
- R11: A fetch and a write to the same word at the same edge return the word as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write or restore strobe |
| wr_addr | input | 10 | Word address of the write |
| wr_data | input | 32 | Write data |
| upset_en | input | 1 | Soft-error model strobe |
| upset_addr | input | 10 | Word to disturb |
| upset_mask | input | 34 | Stored bits to flip (33:32 are parity) |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | 10 | Fetch word address |
| fetch_data | output | 32 | Fetched data |
| fetch_valid | output | 1 | Response is clean |
| fetch_err | output | 1 | Response failed the parity or flag check |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 1 | 0 = backup base, 1 = interrupt clear |
| csr_wdata | input | 32 | CSR write data |
| irq | output | 1 | Sticky recovery interrupt |
| fault_addr | output | 10 | Word address of the recorded fault |
| backup_base | output | 32 | Programmed backup base |
| backup_addr | output | 32 | Backup byte address of the faulting word |

## Verification
A fetch result (fetch_data, fetch_valid, fetch_err) is due one cycle after the edge that accepts the request. The interrupt and the fault address follow one edge after that response cycle. CSR effects appear one edge after the write, and backup_addr tracks its registers with no delay. The bench drives inputs just after the falling edge and runs a behavioural reference model on each rising edge. It compares every output at the next falling edge, so each result is checked in exactly the cycle it is due. Directed checks after each step confirm the corner cases: clearing with a zero bit, a set and a clear in the same cycle, an undetected same-group double flip, and read-during-write.

// File: rtl/ispm_pkg.sv
`timescale 1ns/1ps
package ispm_pkg;
    localparam int WORD_W = 32;
    localparam int PAR_W  = 2;
    localparam int CELL_W = WORD_W + PAR_W;

    typedef enum logic {
        CSR_BASE  = 1'b0,
        CSR_CLEAR = 1'b1
    } csr_sel_e;
endpackage

// File: rtl/ispm_par_gen.sv
`timescale 1ns/1ps
module ispm_par_gen #(
    parameter int W = 32
) (
    input  logic [W-1:0] data,
    output logic [1:0]   par
);
    localparam int HALF = W / 2;

    logic [HALF-1:0] even_bits;
    logic [HALF-1:0] odd_bits;

    for (genvar i = 0; i < HALF; i++) begin : g_split
        assign even_bits[i] = data[2*i];
        assign odd_bits[i]  = data[2*i+1];
    end

    assign par = {^odd_bits, ^even_bits};
endmodule

// File: rtl/ispm_store.sv
`timescale 1ns/1ps
module ispm_store #(
    parameter int AW = 10,
    parameter int CW = 34
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_cell,
    input  logic          flip_en,
    input  logic [AW-1:0] flip_addr,
    input  logic [CW-1:0] flip_mask,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [CW-1:0] rd_cell
);
    localparam int DEPTH = 1 << AW;

    logic [CW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (flip_en) mem[flip_addr] <= mem[flip_addr] ^ flip_mask;
        if (wr_en)   mem[wr_addr]   <= wr_cell;
        if (rd_en)   rd_cell        <= mem[rd_addr];
    end
endmodule

// File: rtl/ispm_fault_ctrl.sv
`timescale 1ns/1ps
module ispm_fault_ctrl
    import ispm_pkg::*;
#(
    parameter int AW     = 10,
    parameter int BASE_W = 32,
    parameter int OFS_SH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [AW-1:0]     fetch_addr,
    input  logic              par_bad,
    input  logic              csr_we,
    input  logic              csr_sel,
    input  logic [BASE_W-1:0] csr_wdata,
    output logic              fetch_valid,
    output logic              fetch_err,
    output logic              irq,
    output logic [AW-1:0]     fault_addr,
    output logic [BASE_W-1:0] backup_base,
    output logic [BASE_W-1:0] backup_addr
);
    typedef struct packed {
        logic              rsp_vld;
        logic [AW-1:0]     rsp_addr;
        logic              irq;
        logic [AW-1:0]     fault;
        logic [BASE_W-1:0] base;
    } ctrl_st_t;

    ctrl_st_t s_d, s_q;
    logic     hit_flagged, bad_rsp, set_req, clr_req;

    always_comb begin
        hit_flagged = s_q.irq && (s_q.rsp_addr == s_q.fault);
        bad_rsp     = s_q.rsp_vld && (par_bad || hit_flagged);
        set_req     = s_q.rsp_vld && par_bad;
        clr_req     = csr_we && (csr_sel == CSR_CLEAR) && csr_wdata[0];

        s_d          = s_q;
        s_d.rsp_vld  = fetch_req;
        s_d.rsp_addr = fetch_addr;

        if (set_req) begin
            s_d.irq = 1'b1;
            if (!s_q.irq || clr_req) s_d.fault = s_q.rsp_addr;
        end else if (clr_req) begin
            s_d.irq = 1'b0;
        end

        if (csr_we && (csr_sel == CSR_BASE)) s_d.base = csr_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fetch_valid = s_q.rsp_vld && !bad_rsp;
    assign fetch_err   = bad_rsp;
    assign irq         = s_q.irq;
    assign fault_addr  = s_q.fault;
    assign backup_base = s_q.base;
    assign backup_addr = s_q.base + (BASE_W'(s_q.fault) << OFS_SH);
endmodule

// File: rtl/ispm_guard.sv
`timescale 1ns/1ps
module ispm_guard
    import ispm_pkg::*;
#(
    parameter  int BYTES  = 4096,
    parameter  int BASE_W = 32,
    localparam int DEPTH  = BYTES / (WORD_W / 8),
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = CELL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              upset_en,
    input  logic [AW-1:0]     upset_addr,
    input  logic [CW-1:0]     upset_mask,
    input  logic              fetch_req,
    input  logic [AW-1:0]     fetch_addr,
    output logic [WORD_W-1:0] fetch_data,
    output logic              fetch_valid,
    output logic              fetch_err,
    input  logic              csr_we,
    input  logic              csr_sel,
    input  logic [BASE_W-1:0] csr_wdata,
    output logic              irq,
    output logic [AW-1:0]     fault_addr,
    output logic [BASE_W-1:0] backup_base,
    output logic [BASE_W-1:0] backup_addr
);
    localparam int OFS_SH = $clog2(WORD_W / 8);

    logic [1:0]    wr_par, rd_par;
    logic [CW-1:0] rd_cell;
    logic          par_bad;

    ispm_par_gen #(.W(WORD_W)) u_wr_par (
        .data (wr_data),
        .par  (wr_par)
    );

    ispm_store #(.AW(AW), .CW(CW)) u_store (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_cell   ({wr_par, wr_data}),
        .flip_en   (upset_en),
        .flip_addr (upset_addr),
        .flip_mask (upset_mask),
        .rd_en     (fetch_req),
        .rd_addr   (fetch_addr),
        .rd_cell   (rd_cell)
    );

    ispm_par_gen #(.W(WORD_W)) u_rd_par (
        .data (rd_cell[WORD_W-1:0]),
        .par  (rd_par)
    );

    assign par_bad    = (rd_par != rd_cell[CW-1:WORD_W]);
    assign fetch_data = rd_cell[WORD_W-1:0];

    ispm_fault_ctrl #(.AW(AW), .BASE_W(BASE_W), .OFS_SH(OFS_SH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .par_bad     (par_bad),
        .csr_we      (csr_we),
        .csr_sel     (csr_sel),
        .csr_wdata   (csr_wdata),
        .fetch_valid (fetch_valid),
        .fetch_err   (fetch_err),
        .irq         (irq),
        .fault_addr  (fault_addr),
        .backup_base (backup_base),
        .backup_addr (backup_addr)
    );
endmodule

// File: rtl/ispm_guard_chk.sv
`timescale 1ns/1ps
module ispm_guard_chk #(
    parameter int AW     = 10,
    parameter int BASE_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_req,
    input logic              fetch_valid,
    input logic              fetch_err,
    input logic              irq,
    input logic [AW-1:0]     fault_addr,
    input logic              csr_we,
    input logic              csr_sel,
    input logic [BASE_W-1:0] csr_wdata
);
    logic clr_w;
    assign clr_w = csr_we && csr_sel && csr_wdata[0];

    p_resp_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_valid && fetch_err));

    p_resp_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid || fetch_err) |-> $past(fetch_req));

    p_irq_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(fetch_err));

    p_irq_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_w) |=> irq);

    p_fault_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_w) |=> $stable(fault_addr));

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w && !fetch_err) |=> !irq);
endmodule

bind ispm_guard ispm_guard_chk #(.AW(AW), .BASE_W(BASE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_req   (fetch_req),
    .fetch_valid (fetch_valid),
    .fetch_err   (fetch_err),
    .irq         (irq),
    .fault_addr  (fault_addr),
    .csr_we      (csr_we),
    .csr_sel     (csr_sel),
    .csr_wdata   (csr_wdata)
);

// File: tb/sim_ispm_guard.sv
`timescale 1ns/1ps
module sim_ispm_guard;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0, upset_en = 0, fetch_req = 0, csr_we = 0, csr_sel = 0;
    logic [9:0]  wr_addr = 0, upset_addr = 0, fetch_addr = 0;
    logic [31:0] wr_data = 0, csr_wdata = 0;
    logic [33:0] upset_mask = 0;
    logic [31:0] fetch_data, backup_base, backup_addr;
    logic        fetch_valid, fetch_err, irq;
    logic [9:0]  fault_addr;

    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ispm_guard u0 (.*);

    function automatic logic [1:0] pp(input logic [31:0] d);
        logic e, o;
        e = 0; o = 0;
        for (int i = 0; i < 32; i++)
            if (i % 2 == 0) e ^= d[i]; else o ^= d[i];
        return {o, e};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model
    logic [33:0] m_mem [1024];
    logic        m_vld, m_irq;
    logic [9:0]  m_addr, m_fault;
    logic [33:0] m_word;
    logic [31:0] m_base;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_vld = 0; m_irq = 0; m_addr = 0; m_fault = 0; m_base = 0; m_word = 0;
        end else begin
            logic mism, clr;
            mism = m_vld && (pp(m_word[31:0]) != m_word[33:32]);
            clr  = csr_we && csr_sel && csr_wdata[0];
            if (mism) begin
                if (!m_irq || clr) m_fault = m_addr;
                m_irq = 1;
            end else if (clr) m_irq = 0;
            if (csr_we && !csr_sel) m_base = csr_wdata;
            m_vld = fetch_req;
            m_addr = fetch_addr;
            if (fetch_req) m_word = m_mem[fetch_addr];
            if (upset_en) m_mem[upset_addr] = m_mem[upset_addr] ^ upset_mask;
            if (wr_en) m_mem[wr_addr] = {pp(wr_data), wr_data};
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic mb;
            mb = m_vld && ((pp(m_word[31:0]) != m_word[33:32]) || (m_irq && m_addr == m_fault));
            chk("R1 fetch_valid", 32'(fetch_valid), 32'(m_vld && !mb));
            chk("R2 fetch_err", 32'(fetch_err), 32'(m_vld && mb));
            if (m_vld && !mb) chk("R1 fetch_data", fetch_data, m_word[31:0]);
            chk("R3 irq", 32'(irq), 32'(m_irq));
            chk("R6 fault_addr", 32'(fault_addr), 32'(m_fault));
            chk("R7 backup_base", backup_base, m_base);
            chk("R7 backup_addr", backup_addr, m_base + 32'(m_fault) * 4);
        end
    end

    task automatic cyc();
        @(posedge clk); @(negedge clk); #1;
        wr_en = 0; upset_en = 0; fetch_req = 0; csr_we = 0;
    endtask
    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1; wr_addr = 10'(a); wr_data = d; cyc();
    endtask
    task automatic fetch(input int a);
        fetch_req = 1; fetch_addr = 10'(a); cyc();
    endtask
    task automatic upset(input int a, input logic [33:0] m);
        upset_en = 1; upset_addr = 10'(a); upset_mask = m; cyc();
    endtask
    task automatic csr(input logic s, input logic [31:0] d);
        csr_we = 1; csr_sel = s; csr_wdata = d; cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1; total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        // R10 reset state
        chk("R10 irq", 32'(irq), 0);
        chk("R10 fault_addr", 32'(fault_addr), 0);
        chk("R10 backup_addr", backup_addr, 0);
        chk("R10 valid/err", 32'({fetch_valid, fetch_err}), 0);
        for (int i = 0; i < 64; i++) wr(i, 32'h9E37_79B9 * (i + 1) ^ 32'(i << 7));
        wr(1023, 32'hFFFF_0001);
        for (int i = 0; i < 64; i++) fetch(i);
        fetch(1023);
        chk("R1 last word", fetch_data, 32'hFFFF_0001);
        csr(1'b0, 32'h8000_0000);

        upset(5, 34'h1);
        fetch(5);
        chk("R2 single flip err", 32'(fetch_err), 1);
        fetch(7);
        chk("R3 irq set", 32'(irq), 1);
        chk("R3 fault 5", 32'(fault_addr), 5);
        chk("R7 backup 0x80000014", backup_addr, 32'h8000_0014);

        upset(9, 34'h8);
        fetch(9);
        chk("R2 err at 9", 32'(fetch_err), 1);
        cyc();
        chk("R6 fault stays 5", 32'(fault_addr), 5);
        wr(5, 32'hCAFE_F00D);
        wr(9, 32'h1234_5678);
        fetch(5);
        chk("R4 flagged word still err", 32'(fetch_err), 1);
        chk("R4 flagged word not valid", 32'(fetch_valid), 0);
        csr(1'b1, 32'h0);
        chk("R5 clear with zero ignored", 32'(irq), 1);
        csr(1'b1, 32'h1);
        chk("R5 cleared", 32'(irq), 0);
        fetch(5);
        chk("R8 restored valid", 32'(fetch_valid), 1);
        chk("R8 restored data", fetch_data, 32'hCAFE_F00D);
        fetch(9);
        chk("R8 restored 9", fetch_data, 32'h1234_5678);

        upset(10, 34'h5);
        fetch(10);
        chk("R9 same-group pair undetected", 32'(fetch_valid), 1);
        upset(11, 34'h70);
        fetch(11);
        chk("R9 burst3 detected", 32'(fetch_err), 1);
        cyc();
        csr(1'b1, 32'h1);
        upset(12, 34'h6);
        fetch(12);
        chk("R9 adjacent pair detected", 32'(fetch_err), 1);
        cyc();
        csr(1'b1, 32'h1);
        upset(13, 34'h1_0000_0000);
        fetch(13);
        chk("R9 parity bit flip detected", 32'(fetch_err), 1);
        cyc();
        csr(1'b1, 32'h1);

        upset(14, 34'h2);
        fetch(14);
        csr(1'b1, 32'h1);
        chk("R5 set wins over clear", 32'(irq), 1);
        chk("R5 fault takes 14", 32'(fault_addr), 14);
        csr(1'b1, 32'h1);
        csr(1'b0, 32'h0000_F000);
        chk("R7 new base", backup_addr, 32'h0000_F000 + 14 * 4);

        wr_en = 1; wr_addr = 20; wr_data = 32'hDEAD_BEEF;
        fetch_req = 1; fetch_addr = 20;
        cyc();
        chk("R11 old word on rdw", fetch_data, 32'h9E37_79B9 * 21 ^ 32'(20 << 7));
        fetch(20);
        chk("R11 new word after", fetch_data, 32'hDEAD_BEEF);

        repeat (3) cyc();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule